// File: doc/BRIEF.md
# Misaligned Access Sub-Access Splitter

This block sits between a load/store pipeline and a translated memory port. It takes one request at a time. A request carries an address, a size of 1, 2, 4 or 8 bytes, a read/write flag and store data. When the request is misaligned, the block breaks it into naturally aligned pieces and issues them one after another. Each piece goes out on its own request/response handshake, so the translation stage downstream looks up every piece separately. A piece that lies on one side of a 4 KiB page boundary can therefore map to a different physical page than a piece on the other side.

Two configuration inputs control the split. The granularity input selects single-byte pieces or the widest aligned pieces that fit. The direction input selects whether the lowest or the highest address is issued first. Load bytes are gathered into a right-justified result and then zero- or sign-extended. The first piece that returns a fault ends the request, and the address of that piece is reported. A third input forces a naturally aligned request through the split path, which lets the split behaviour be compared with the unsplit result.

Top module: `misalign_splitter`

## Requirements
- R1: A request whose address is a multiple of its size, with the force-split input low, is issued as exactly one sub-access at the request address with the request size. The size code is 0/1/2/3 for 1/2/4/8 bytes.
- R2: In widest-unit mode, each sub-access of a split request has the largest power-of-two size that is aligned at the current cursor and does not exceed the bytes still outstanding. For example, 8 bytes at 0x101 issued low first go out as 1@0x101, 2@0x102, 4@0x104, 1@0x108.
- R3: In byte mode (granularity input high), every sub-access of a split request is 1 byte.
- R4: With the direction input low, sub-accesses go out in strictly ascending address order, starting at the request address. With it high, they go out in strictly descending order, starting at the highest piece. The configuration inputs must stay unchanged while a request is in progress.
- R5: No sub-access spans a page boundary (PAGE_BITS = 12). A request that crosses one is split at the boundary.
- R6: Each load byte is placed at its offset from the request address within the result. The result is then zero-extended when the unsigned input is high and sign-extended otherwise, from bit 8*size-1.
- R7: Each store sub-access carries, right-justified on the write data bus, the store-data bytes at its offsets from the request address.
- R8: A sub-access answered with a fault ends the request. The done pulse then shows the fault flag and that sub-access's address, and no further sub-access is issued.
- R9: With force-split high, an aligned request goes through the split path (bytes in byte mode) and returns the same load result as the unsplit access.
- R10: The block is ready for a new request only when idle. Completion is a one-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte_mode | input | 1 | 1: split into bytes, 0: widest aligned units |
| cfg_high_first | input | 1 | 1: highest address first, 0: lowest first |
| cfg_force_split | input | 1 | Send aligned requests through the split path |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Request virtual address |
| req_size | input | 2 | Size code, bytes = 1 << code |
| req_write | input | 1 | 1: store, 0: load |
| req_unsigned | input | 1 | Zero-extend load result |
| req_wdata | input | 64 | Store data, right-justified |
| mem_valid | output | 1 | Sub-access request |
| mem_ready | input | 1 | Sub-access accepted |
| mem_addr | output | ADDR_W | Sub-access virtual address |
| mem_size | output | 2 | Sub-access size code |
| mem_write | output | 1 | Sub-access is a store |
| mem_wdata | output | 64 | Sub-access store data, right-justified |
| mem_rsp_valid | input | 1 | Sub-access response |
| mem_rsp_fault | input | 1 | Translation or access fault on the sub-access |
| mem_rsp_data | input | 64 | Load data, right-justified |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Request ended on a fault |
| done_fault_addr | output | ADDR_W | Address of the faulting sub-access |
| done_rdata | output | 64 | Extended load result |

## Verification
Loads are issued at an aligned address, at odd addresses inside a page, and across a page boundary, in both directions and both granularities. The count, first address, last address and first size of the sub-accesses separate widest-unit splitting from byte splitting and ascending order from descending. Load data follows a per-address byte pattern with negative top bytes, so any misplaced byte or wrong extension shows up in the result. A store crossing an 8-byte boundary checks byte placement in memory. A fault placed on the upper page shows that the request stops at the first faulting piece in either direction.

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_byte_mode,
  input  logic              cfg_high_first,
  input  logic              cfg_force_split,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_unsigned,
  input  logic [63:0]       req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_write,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_fault,
  input  logic [63:0]       mem_rsp_data,
  output logic              done_valid,
  output logic              done_fault,
  output logic [ADDR_W-1:0] done_fault_addr,
  output logic [63:0]       done_rdata
);
  localparam int PAD = ADDR_W - 4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] base_q, sub_addr_q;
  logic [1:0]        size_q, sub_code_q;
  logic              write_q, uns_q, split_q, fault_q;
  logic [63:0]       wdata_q, rdata_q;
  logic [3:0]        lo_off, hi_off, sub_off_q;

  function automatic logic [1:0] pick(input logic [2:0] low3, input logic [3:0] rem,
                                      input logic bytes_only);
    if (bytes_only)                        pick = 2'd0;
    else if (low3 == 3'd0 && rem >= 4'd8)  pick = 2'd3;
    else if (low3[1:0] == 2'd0 && rem >= 4'd4) pick = 2'd2;
    else if (low3[0] == 1'b0 && rem >= 4'd2)   pick = 2'd1;
    else                                   pick = 2'd0;
  endfunction

  logic [3:0]        req_bytes, rem, sub_len, sub_off, len_q;
  logic              req_aligned;
  logic [ADDR_W-1:0] cursor;
  logic [1:0]        sub_code;

  assign req_bytes   = 4'd1 << req_size;
  assign req_aligned = (req_addr[2:0] & (req_bytes[2:0] - 3'd1)) == 3'd0;
  assign rem         = hi_off - lo_off;
  assign cursor      = base_q + {{PAD{1'b0}}, cfg_high_first ? hi_off : lo_off};
  assign sub_code    = pick(cursor[2:0], rem, cfg_byte_mode & split_q);
  assign sub_len     = 4'd1 << sub_code;
  assign sub_off     = cfg_high_first ? hi_off - sub_len : lo_off;
  assign len_q       = 4'd1 << sub_code_q;

  assign req_ready  = state == S_IDLE;
  assign mem_valid  = state == S_ISSUE;
  assign mem_addr   = base_q + {{PAD{1'b0}}, sub_off};
  assign mem_size   = sub_code;
  assign mem_write  = write_q;
  assign mem_wdata  = wdata_q >> {sub_off, 3'b000};
  assign done_valid = state == S_DONE;
  assign done_fault = fault_q;
  assign done_fault_addr = sub_addr_q;

  logic [63:0] rsp_mask;
  assign rsp_mask = (sub_code_q == 2'd3) ? '1 : ((64'd1 << {len_q, 3'b000}) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base_q <= '0; sub_addr_q <= '0; size_q <= '0; sub_code_q <= '0;
      write_q <= 1'b0; uns_q <= 1'b0; split_q <= 1'b0; fault_q <= 1'b0;
      wdata_q <= '0; rdata_q <= '0; lo_off <= '0; hi_off <= '0; sub_off_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          base_q  <= req_addr;
          size_q  <= req_size;
          write_q <= req_write;
          uns_q   <= req_unsigned;
          wdata_q <= req_wdata;
          split_q <= cfg_force_split | ~req_aligned;
          lo_off  <= 4'd0;
          hi_off  <= req_bytes;
          rdata_q <= '0;
          fault_q <= 1'b0;
          state   <= S_ISSUE;
        end
        S_ISSUE: if (mem_ready) begin
          sub_addr_q <= mem_addr;
          sub_code_q <= sub_code;
          sub_off_q  <= sub_off;
          state      <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_fault) begin
            fault_q <= 1'b1;
            state   <= S_DONE;
          end else begin
            rdata_q <= rdata_q | ((mem_rsp_data & rsp_mask) << {sub_off_q, 3'b000});
            if (cfg_high_first) hi_off <= hi_off - len_q;
            else                lo_off <= lo_off + len_q;
            state <= (rem == len_q) ? S_DONE : S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (size_q)
      2'd0: done_rdata = {{56{~uns_q & rdata_q[7]}},  rdata_q[7:0]};
      2'd1: done_rdata = {{48{~uns_q & rdata_q[15]}}, rdata_q[15:0]};
      2'd2: done_rdata = {{32{~uns_q & rdata_q[31]}}, rdata_q[31:0]};
      default: done_rdata = rdata_q;
    endcase
  end

  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0; have_prev <= 1'b0;
    end else if (state == S_IDLE) begin
      have_prev <= 1'b0;
    end else if (state == S_WAIT && mem_rsp_valid) begin
      prev_addr <= sub_addr_q; have_prev <= 1'b1;
    end
  end

  logic [ADDR_W-1:0] mem_last;
  assign mem_last = mem_addr + {{PAD{1'b0}}, sub_len - 4'd1};

  a_r1_unsplit_whole: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !split_q |-> mem_size == size_q && mem_addr == base_q);
  a_r2_natural_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[2:0] & ((3'd1 << mem_size) - 3'd1)) == 3'd0);
  a_r3_byte_units: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && split_q && cfg_byte_mode |-> mem_size == 2'd0);
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && have_prev |-> (cfg_high_first ? mem_addr < prev_addr : mem_addr > prev_addr));
  a_r4_cfg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE && $past(state) != S_IDLE |->
      $stable({cfg_byte_mode, cfg_high_first, cfg_force_split}));
  a_r5_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_last[ADDR_W-1:PAGE_BITS] == mem_addr[ADDR_W-1:PAGE_BITS]);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);
endmodule

// File: tb/misalign_splitter_bench.sv
`timescale 1ns/1ps
module misalign_splitter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_byte_mode = 0, cfg_high_first = 0, cfg_force_split = 0;
  logic req_valid = 0, req_ready, req_write = 0, req_unsigned = 0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata;
  logic mem_rsp_valid = 0, mem_rsp_fault = 0;
  logic [63:0] mem_rsp_data = '0;
  logic done_valid, done_fault;
  logic [31:0] done_fault_addr;
  logic [63:0] done_rdata;

  assign mem_ready = 1'b1;

  misalign_splitter u_misalign_splitter (.*);

  int checks = 0, fails = 0;
  logic fault_en = 0;
  logic [7:0]  wmem [0:255];
  logic [31:0] log_addr [0:63];
  logic [1:0]  log_size [0:63];
  int log_n = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < 256; i++) wmem[i] = 8'h00;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_valid && mem_ready) begin
      log_addr[log_n % 64] <= mem_addr;
      log_size[log_n % 64] <= mem_size;
      log_n <= log_n + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_fault <= fault_en && (mem_addr[31:12] == 20'd1);
      for (int i = 0; i < 8; i++) begin
        mem_rsp_data[i*8 +: 8] <= (i < (1 << mem_size)) ? pat(mem_addr + i) : 8'h00;
        if (mem_write && i < (1 << mem_size))
          wmem[(mem_addr[7:0] + i) % 256] <= mem_wdata[i*8 +: 8];
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int r_n;
  logic [31:0] r_first, r_last;
  logic [1:0]  r_fsz;

  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                     input logic uns, input logic [63:0] wd);
    int start;
    start = log_n;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_write = wr;
    req_unsigned = uns; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R10 ready low while busy", {63'd0, req_ready}, 64'd0);
    while (!done_valid) @(negedge clk);
    r_n = log_n - start;
    r_first = log_addr[start % 64];
    r_fsz = log_size[start % 64];
    r_last = log_addr[(log_n - 1) % 64];
  endtask

  function automatic logic [63:0] expect_load(input logic [31:0] a, input logic [1:0] sz,
                                              input logic uns);
    logic [63:0] v;
    int nb;
    nb = 1 << sz;
    v = '0;
    for (int i = 0; i < 8; i++) if (i < nb) v[i*8 +: 8] = pat(a + i);
    if (!uns && nb < 8 && v[nb*8-1]) for (int i = 0; i < 64; i++) if (i >= nb*8) v[i] = 1'b1;
    return v;
  endfunction

  typedef struct packed {
    logic [31:0] addr; logic [1:0] size; logic uns, bm, hf, fs;
    logic [3:0] n; logic [31:0] first; logic [1:0] fsz; logic [31:0] last;
  } vec_t;

  // R1 aligned, R2 widest units, R3 bytes, R4 order, R5 page crossing, R6 extension, R9 force split
  localparam vec_t VEC [13] = '{
    '{32'h100, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 32'h100,  2'd3, 32'h100},
    '{32'h101, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 32'h101,  2'd0, 32'h108},
    '{32'h101, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 32'h108,  2'd0, 32'h101},
    '{32'h101, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8, 32'h101,  2'd0, 32'h108},
    '{32'h101, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8, 32'h108,  2'd0, 32'h101},
    '{32'hFFE, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 32'hFFE,  2'd1, 32'h1000},
    '{32'hFFD, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 32'h1004, 2'd0, 32'hFFD},
    '{32'h1A3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 32'h1A3,  2'd0, 32'h1A4},
    '{32'h1A3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 32'h1A3,  2'd0, 32'h1A4},
    '{32'h108, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4, 32'h108,  2'd0, 32'h10B},
    '{32'h108, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 32'h108,  2'd2, 32'h108},
    '{32'h110, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 32'h110,  2'd3, 32'h110},
    '{32'h1A2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4, 32'h1A5,  2'd0, 32'h1A2}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset ready", {63'd0, req_ready}, 64'd1);
    check("R10 reset mem_valid", {63'd0, mem_valid}, 64'd0);
    check("R10 reset done", {63'd0, done_valid}, 64'd0);
    rst_n = 1;

    foreach (VEC[k]) begin
      @(negedge clk);
      cfg_byte_mode = VEC[k].bm; cfg_high_first = VEC[k].hf; cfg_force_split = VEC[k].fs;
      run(VEC[k].addr, VEC[k].size, 1'b0, VEC[k].uns, 64'd0);
      check($sformatf("R2 count v%0d", k), 64'(r_n), 64'(VEC[k].n));
      check($sformatf("R4 first addr v%0d", k), 64'(r_first), 64'(VEC[k].first));
      check($sformatf("R4 last addr v%0d", k), 64'(r_last), 64'(VEC[k].last));
      check($sformatf("R1 first size v%0d", k), 64'(r_fsz), 64'(VEC[k].fsz));
      check($sformatf("R6 load data v%0d", k), done_rdata,
            expect_load(VEC[k].addr, VEC[k].size, VEC[k].uns));
      check($sformatf("R8 no fault v%0d", k), {63'd0, done_fault}, 64'd0);
      @(negedge clk);
      check($sformatf("R10 done pulse v%0d", k), {63'd0, done_valid}, 64'd0);
    end

    // R7 store across 8-byte boundary, widest units, high first
    @(negedge clk);
    cfg_byte_mode = 0; cfg_high_first = 1; cfg_force_split = 0;
    run(32'h1F5, 2'd2, 1'b1, 1'b0, 64'h0000_0000_1122_3344);
    check("R7 store count", 64'(r_n), 64'd3);
    check("R7 store first", 64'(r_first), 64'h1F8);
    @(negedge clk);
    check("R7 byte F5", 64'(wmem[8'hF5]), 64'h44);
    check("R7 byte F6", 64'(wmem[8'hF6]), 64'h33);
    check("R7 byte F7", 64'(wmem[8'hF7]), 64'h22);
    check("R7 byte F8", 64'(wmem[8'hF8]), 64'h11);
    check("R7 byte F9 untouched", 64'(wmem[8'hF9]), 64'h00);

    // R8 fault on upper page, low first: stops at third piece 4@0x1000
    fault_en = 1;
    cfg_high_first = 0;
    run(32'hFFD, 2'd3, 1'b0, 1'b0, 64'd0);
    check("R8 fault flag low", {63'd0, done_fault}, 64'd1);
    check("R8 fault addr low", 64'(done_fault_addr), 64'h1000);
    check("R8 pieces low", 64'(r_n), 64'd3);

    // R8 fault, high first: first piece 1@0x1004 faults
    @(negedge clk);
    cfg_high_first = 1;
    run(32'hFFD, 2'd3, 1'b0, 1'b0, 64'd0);
    check("R8 fault flag high", {63'd0, done_fault}, 64'd1);
    check("R8 fault addr high", 64'(done_fault_addr), 64'h1004);
    check("R8 pieces high", 64'(r_n), 64'd1);
    fault_en = 0;

    // R9 force split in byte mode equals unsplit result
    @(negedge clk);
    cfg_byte_mode = 1; cfg_high_first = 0; cfg_force_split = 1;
    run(32'h1A0, 2'd3, 1'b0, 1'b0, 64'd0);
    check("R9 forced pieces", 64'(r_n), 64'd8);
    check("R9 forced data", done_rdata, expect_load(32'h1A0, 2'd3, 1'b0));

    repeat (2) @(negedge clk);
    summary();
  end
endmodule